// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block computes a signed multiply-accumulate, R = A × B + C, where A (the multiplicand) and B (the multiplier) are N-bit two's-complement operands and C is a 2N-bit addend. The result is taken modulo 2^(2N). The operands are captured in an input register. The radix-4 Booth recoding of B and the negation of A are both formed in parallel from that register. A partial-product array of exactly N/2 rows is reduced together with the addend by layers of 3:2 carry-save compressors. A final carry-propagate adder then feeds a single output register.

The array needs no correction row for negative digits. In every row except the top one, the negation carry is merged into a rewritten least-significant bit plus one "hot-two" bit, which sits one column to the left and is carried in the next row. The top row takes ±A or ±2A directly from the precomputed negation, so it leaves no carry behind. Sign extension is replaced by a few complemented sign bits and constant ones. The residual constants cancel modulo 2^(2N) with a single extra 1 at column 2N−2.

N must be even and at least 6. The default is 16.

Top module: `booth_mac`

## Requirements
- R1: For any operands, `result_o` equals (sext(A) × sext(B) + C) mod 2^(2N), where A is `op_a_i`, B is `op_b_i` and C is `addend_i`, all in two's complement.
- R2: The output changes two rising edges after the operands are sampled. Operands present at edge k give their result after edge k+1, and the previous result stays on `result_o` between those edges.
- R3: `rst` is a synchronous, active-high reset. After any edge at which `rst` is sampled high, `result_o` is 0, and it is still 0 after the first edge following release.
- R4: When A = B = −2^(N−1), the result is 2^(2N−2) + C (for N=16 with C=0, 0x40000000), with no sign error.
- R5: When A = 0 or B = 0, the result equals C exactly. When B = −1 (all ones), the result is C − A.
- R6: The top Booth digit, formed from B[N−1], B[N−2] and B[N−3], drives the top row correctly for each of its values −2, −1, 0, +1 and +2. Examples for N=16 are B = 0x8000, 0xC000, 0x4000 and 0x6000.
- R7: The addition of C wraps modulo 2^(2N). For N=16, A×B = 1 with C = 0xFFFFFFFF gives 0, and with C = 0x7FFFFFFF gives 0x80000000.
- R8: A = −2^(N−1) combined with negative Booth digits gives the positive magnitude without truncation. For N=16: B=−1 gives 0x00008000, B=−2 gives 0x00010000, and B=0xC000 gives 0x20000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a_i | input | N | Signed multiplicand A |
| op_b_i | input | N | Signed multiplier B, Booth-recoded |
| addend_i | input | 2N | Addend C |
| result_o | output | 2N | Registered A×B+C modulo 2^(2N) |

## Verification
The bench builds the block with its default N=16. This gives eight Booth rows: six middle rows with the {1, ~s} sign pair, the first row with its triple, and a top row that spans columns 14 to 31. With that width, the most negative operand, the negated 2^15 needed by the top row, and the compensation constant at column 30 can all be reached directly. Table vectors and directed cases hit every top-digit value and addend wrap-around. Several thousand random operand sets then exercise mixed digit patterns in every row.

// File: rtl/booth_mac_pkg.sv
`timescale 1ns/1ps
package booth_mac_pkg;

  // Booth digit controls: sign selects and magnitude selects (one-hot or none)
  typedef struct packed {
    logic pos;
    logic neg;
    logic one;
    logic two;
  } bsel_t;

  // Recode one overlapping triplet {b[2i+1], b[2i], b[2i-1]}
  function automatic bsel_t encode_group(input logic [2:0] g);
    bsel_t s;
    s.one = g[1] ^ g[0];
    s.two = (g[2] & ~g[1] & ~g[0]) | (~g[2] & g[1] & g[0]);
    s.neg = g[2] & ~(g[1] & g[0]);
    s.pos = ~g[2] & (g[1] | g[0]);
    return s;
  endfunction

endpackage

// File: rtl/booth_mac_enc.sv
`timescale 1ns/1ps
module booth_mac_enc
  import booth_mac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]         mult_i,
  output bsel_t [N/2-1:0]      sel_o
);
  localparam int R = N / 2;

  // multiplier with the implicit zero below bit 0
  logic [N:0] ext;
  assign ext = {mult_i, 1'b0};

  for (genvar i = 0; i < R; i++) begin : g_digit
    assign sel_o[i] = encode_group(ext[2*i+2 -: 3]);
  end

endmodule

// File: rtl/booth_mac_pprow.sv
`timescale 1ns/1ps
module booth_mac_pprow
  import booth_mac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] mcand_i,
  input  bsel_t        sel_i,
  output logic [N:0]   bits_o,   // bit 0 is the merged LSB, bit N is the row sign
  output logic         hot2_o    // negation carry folded into the next column up
);
  logic [N:0] xe;
  assign xe = {mcand_i[N-1], mcand_i};

  // AND-OR selection, no XOR stage
  for (genvar j = 1; j <= N; j++) begin : g_bit
    logic hi, lo;
    assign hi = xe[j];
    assign lo = mcand_i[j-1];
    assign bits_o[j] = (((hi & sel_i.pos) | (~hi & sel_i.neg)) & sel_i.one)
                     | (((lo & sel_i.pos) | (~lo & sel_i.neg)) & sel_i.two);
  end

  // merged LSB plus hot-two replace (raw LSB + negation carry)
  assign bits_o[0] = mcand_i[0] & sel_i.one;
  assign hot2_o    = sel_i.neg & (sel_i.two | ~mcand_i[0]);

endmodule

// File: rtl/booth_mac_lastrow.sv
`timescale 1ns/1ps
module booth_mac_lastrow
  import booth_mac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] mcand_i,
  input  logic [N:0]   negx_i,   // -A, N+1 bits
  input  bsel_t        sel_i,
  output logic [N+1:0] row_o     // exact digit*A, N+2 bits, no trailing carry
);
  logic [N+1:0] p1, p2, n1, n2;
  logic         s_p1, s_p2, s_n1, s_n2;

  assign p1 = {mcand_i[N-1], mcand_i[N-1], mcand_i};
  assign p2 = {mcand_i[N-1], mcand_i, 1'b0};
  assign n1 = {negx_i[N], negx_i};
  assign n2 = {negx_i, 1'b0};

  assign s_p1 = sel_i.pos & sel_i.one;
  assign s_p2 = sel_i.pos & sel_i.two;
  assign s_n1 = sel_i.neg & sel_i.one;
  assign s_n2 = sel_i.neg & sel_i.two;

  // five-way choice: zero when no select is active
  assign row_o = ({(N+2){s_p1}} & p1) | ({(N+2){s_p2}} & p2)
               | ({(N+2){s_n1}} & n1) | ({(N+2){s_n2}} & n2);

endmodule

// File: rtl/booth_mac_csa.sv
`timescale 1ns/1ps
module booth_mac_csa #(
  parameter int W = 32,
  parameter int K = 9
) (
  input  logic [K*W-1:0] rows_i,
  output logic [W-1:0]   sum_o,
  output logic [W-1:0]   carry_o
);

  // Level-by-level 3:2 reduction until two vectors remain
  function automatic logic [2*W-1:0] reduce_rows(input logic [K*W-1:0] flat);
    logic [W-1:0] cur [K];
    logic [W-1:0] nxt [K];
    int cnt, grp, nc;
    for (int k = 0; k < K; k++) cur[k] = flat[k*W +: W];
    cnt = K;
    for (int lv = 0; lv < K; lv++) begin
      if (cnt > 2) begin
        grp = cnt / 3;
        nc  = 0;
        for (int k = 0; k < K; k++) nxt[k] = '0;
        for (int g = 0; g < K / 3; g++) begin
          if (g < grp) begin
            nxt[nc]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[nc+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2])
                        | (cur[3*g+1] & cur[3*g+2])) << 1;
            nc = nc + 2;
          end
        end
        for (int r = 0; r < 2; r++) begin
          if (3*grp + r < cnt) begin
            nxt[nc] = cur[3*grp + r];
            nc = nc + 1;
          end
        end
        cur = nxt;
        cnt = nc;
      end
    end
    return {cur[1], cur[0]};
  endfunction

  logic [2*W-1:0] pair;
  assign pair    = reduce_rows(rows_i);
  assign sum_o   = pair[W-1:0];
  assign carry_o = pair[2*W-1:W];

endmodule

// File: rtl/booth_mac.sv
`timescale 1ns/1ps
module booth_mac
  import booth_mac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   op_a_i,
  input  logic [N-1:0]   op_b_i,
  input  logic [2*N-1:0] addend_i,
  output logic [2*N-1:0] result_o
);
  localparam int R = N / 2;     // partial-product rows
  localparam int W = 2 * N;     // result width
  localparam int K = R + 1;     // rows plus the addend
  typedef logic [W-1:0] word_t;

  logic [N-1:0] a_q, b_q;
  word_t        c_q, res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      a_q <= op_a_i;
      b_q <= op_b_i;
      c_q <= addend_i;
    end
  end

  // negation of A, in parallel with recoding of B
  logic [N:0] negx;
  assign negx = ~{a_q[N-1], a_q} + 1'b1;

  bsel_t [R-1:0] sel;
  booth_mac_enc #(.N(N)) enc_i (.mult_i(b_q), .sel_o(sel));

  logic [N:0]   pp_bits [R-1];
  logic [R-2:0] hot2;
  for (genvar i = 0; i < R - 1; i++) begin : g_pp
    booth_mac_pprow #(.N(N)) row_i (
      .mcand_i(a_q), .sel_i(sel[i]), .bits_o(pp_bits[i]), .hot2_o(hot2[i])
    );
  end

  logic [N+1:0] top_row;
  booth_mac_lastrow #(.N(N)) last_i (
    .mcand_i(a_q), .negx_i(negx), .sel_i(sel[R-1]), .row_o(top_row)
  );

  // Array assembly: sign-encoded rows, hot-two bits one row up
  logic [K*W-1:0] flat;
  for (genvar i = 0; i < R; i++) begin : g_row
    if (i == 0) begin : g_first
      assign flat[0 +: W] = word_t'({~pp_bits[0][N], pp_bits[0][N], pp_bits[0]});
    end else if (i < R - 1) begin : g_mid
      word_t comp;
      if (i == R - 2) begin : g_comp
        assign comp = word_t'(1) << (W - 2);
      end else begin : g_nocomp
        assign comp = '0;
      end
      assign flat[i*W +: W] =
          (word_t'({1'b1, ~pp_bits[i][N], pp_bits[i][N-1:0]}) << (2*i))
        | (word_t'(hot2[i-1]) << (2*i - 1))
        | comp;
    end else begin : g_top
      assign flat[i*W +: W] =
          (word_t'({~top_row[N+1], top_row[N:0]}) << (N - 2))
        | (word_t'(hot2[R-2]) << (N - 3));
    end
  end
  assign flat[R*W +: W] = c_q;

  word_t sum_v, carry_v;
  booth_mac_csa #(.W(W), .K(K)) tree_i (.rows_i(flat), .sum_o(sum_v), .carry_o(carry_v));

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= sum_v + carry_v;
  end

  assign result_o = res_q;

endmodule

// File: rtl/booth_mac_chk.sv
`timescale 1ns/1ps
module booth_mac_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   op_a_i,
  input logic [N-1:0]   op_b_i,
  input logic [2*N-1:0] addend_i,
  input logic [2*N-1:0] result_o
);
  localparam int W = 2 * N;
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

  logic [1:0] warm;
  logic       seen = 1'b0;
  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  logic [W-1:0] a_ext, b_ext, model_v;
  assign a_ext   = {{N{op_a_i[N-1]}}, op_a_i};
  assign b_ext   = {{N{op_b_i[N-1]}}, op_b_i};
  assign model_v = a_ext * b_ext + addend_i;

  // R1
  mac_value_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (result_o == $past(model_v, 2)));

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (result_o == '0));

  // R4
  min_square_chk: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && $past((op_a_i == MOST_NEG) && (op_b_i == MOST_NEG), 2))
    |-> (result_o == $past(addend_i, 2) + (W'(1) << (W - 2))));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && $past((op_a_i == '0) || (op_b_i == '0), 2))
    |-> (result_o == $past(addend_i, 2)));

  // R8
  neg_min_chk: assert property (@(posedge clk) disable iff (rst)
    ((warm == 2'd2) && $past((op_a_i == MOST_NEG) && (op_b_i == '1), 2))
    |-> (result_o == $past(addend_i, 2) + (W'(1) << (N - 1))));

endmodule

bind booth_mac booth_mac_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .addend_i(addend_i), .result_o(result_o)
);

// File: tb/booth_mac_tb_top.sv
`timescale 1ns/1ps
module booth_mac_tb_top;
  localparam int N = 16;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] op_a, op_b;
  logic [W-1:0] addend, result;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  booth_mac #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .op_a_i(op_a), .op_b_i(op_b),
    .addend_i(addend), .result_o(result)
  );

  // table: {A, B, C, expected}
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    {16'h0003, 16'h0005, 32'h00000000, 32'h0000000F},
    {16'hFFFD, 16'h0007, 32'h00000000, 32'hFFFFFFEB},
    {16'h8000, 16'h8000, 32'h00000000, 32'h40000000},
    {16'h8000, 16'h7FFF, 32'h00000000, 32'hC0008000},
    {16'h7FFF, 16'h7FFF, 32'h00000000, 32'h3FFF0001},
    {16'hFFFF, 16'hFFFF, 32'h00000000, 32'h00000001},
    {16'h1234, 16'h0000, 32'h0000ABCD, 32'h0000ABCD},
    {16'h0000, 16'hFFFF, 32'h12345678, 32'h12345678},
    {16'hFFFF, 16'h8000, 32'h00000000, 32'h00008000},
    {16'h0002, 16'h0003, 32'hFFFFFFFF, 32'h00000005},
    {16'h7FFF, 16'h7FFF, 32'hFFFFFFFF, 32'h3FFF0000},
    {16'h8000, 16'h8000, 32'hC0000000, 32'h00000000},
    {16'h8000, 16'h0003, 32'h00000000, 32'hFFFE8000},
    {16'h0064, 16'hFF9C, 32'h00002710, 32'h00000000}
  };

  function automatic logic [W-1:0] mac_ref(input logic [N-1:0] a, input logic [N-1:0] b,
                                           input logic [W-1:0] c);
    logic [W-1:0] ae, be;
    ae = {{N{a[N-1]}}, a};
    be = {{N{b[N-1]}}, b};
    return ae * be + c;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, wait two rising edges, sample at the next falling edge
  task automatic run(input string tag, input logic [N-1:0] a, input logic [N-1:0] b,
                     input logic [W-1:0] c, input logic [W-1:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; addend = c;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, result, exp);
  endtask

  task automatic run_ref(input string tag, input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [W-1:0] c);
    run(tag, a, b, c, mac_ref(a, b, c));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    op_a = 16'h0007; op_b = 16'h0009; addend = 32'd100;
    // R3: held in reset with nonzero operands
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 during reset", result, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 first edge after release", result, '0);
    // R2: result arrives on the second edge
    @(posedge clk);
    @(negedge clk);
    check("R2 second edge after release", result, 32'd163);

    // R1: table
    for (int i = 0; i < NV; i++) begin
      run("R1 table", VEC[i][95:80], VEC[i][79:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R2: previous result holds for one edge, new one after the second
    run("R2 setup", 16'h0010, 16'h0010, 32'h0, 32'h00000100);
    @(negedge clk);
    op_a = 16'h0020; op_b = 16'h0003; addend = 32'h5;
    @(posedge clk);
    @(negedge clk);
    check("R2 hold after one edge", result, 32'h00000100);
    @(posedge clk);
    @(negedge clk);
    check("R2 update after two edges", result, 32'h00000065);

    // R4
    run("R4 min*min", 16'h8000, 16'h8000, 32'h0, 32'h40000000);
    run("R4 min*min+1", 16'h8000, 16'h8000, 32'h1, 32'h40000001);

    // R5
    run("R5 B zero", 16'h5A5A, 16'h0000, 32'hDEADBEEF, 32'hDEADBEEF);
    run("R5 A zero", 16'h0000, 16'h8000, 32'h0BADF00D, 32'h0BADF00D);
    run("R5 B minus one", 16'h0123, 16'hFFFF, 32'h00001000, 32'h00000EDD);

    // R6: top digit values -2, -1, 0, +1, +2 (and a lower digit)
    run("R6 top -2", 16'h1357, 16'h8000, 32'h0, 32'hF6548000);
    run("R6 top -1", 16'h1357, 16'hC000, 32'h0, 32'hFB2A4000);
    run("R6 top +1", 16'h1357, 16'h4000, 32'h0, 32'h04D5C000);
    run("R6 top +2", 16'h0001, 16'h6000, 32'h0, 32'h00006000);
    run("R6 top 0", 16'h0003, 16'h1000, 32'h0, 32'h00003000);
    run_ref("R6 top -2 negative A", 16'h8001, 16'h8000, 32'h0);
    run_ref("R6 top +2 negative A", 16'hFFFB, 16'h6000, 32'h12);

    // R7
    run("R7 wrap to zero", 16'h0001, 16'h0001, 32'hFFFFFFFF, 32'h00000000);
    run("R7 wrap to sign", 16'h0001, 16'h0001, 32'h7FFFFFFF, 32'h80000000);

    // R8
    run("R8 min*-1", 16'h8000, 16'hFFFF, 32'h0, 32'h00008000);
    run("R8 min*-2", 16'h8000, 16'hFFFE, 32'h0, 32'h00010000);
    run("R8 min*C000", 16'h8000, 16'hC000, 32'h0, 32'h20000000);

    // R1: patterned and random operands
    run_ref("R1 alternating", 16'hAAAA, 16'h5555, 32'h13579BDF);
    run_ref("R1 alternating", 16'h5555, 16'hAAAA, 32'hFEDCBA98);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r0, r1;
      r0 = $urandom();
      r1 = $urandom();
      run_ref("R1 random", r0[15:0], r0[31:16], r1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule